// File: doc/BRIEF.md
# Byte-Coded Operand Resolver and ALU

This block executes one three-byte instruction per handshake: an opcode byte followed by two operand bytes. Each operand byte is classed by its numeric range. Low values are immediate literals. A band of codes names a register, whose current value the block reads from the register-file inputs. The value 0xFF means the operand is absent. Any other byte is illegal as an operand. The opcode selects one of four groups: two-operand arithmetic and logic on the accumulator, shifts of a named register, unsigned compares that can request a skip of the next instruction, and wide-literal operations. In the wide-literal group the two operand bytes are joined into one 16-bit immediate, which always acts on the accumulator.

Instructions enter on a valid/ready channel, and the register-file values are sampled in the same cycle. Each accepted instruction yields exactly one result beat on an output valid/ready channel, one cycle later. A result beat carries a write request (enable, destination register code, data), a skip flag and a 4-bit status. The output holds one beat. While that beat waits with `out_ready` low, `in_ready` stays low and the beat does not change. A beat may leave and a new instruction may enter in the same cycle. Fetch, stack and program storage live outside the block.

Top module: `byte_op_alu`

## Requirements
- R1: Operand bytes 0x00–0x9F are literals, zero-extended. Register codes read these inputs: 0xD0 accumulator, 0xD1 status, 0xD2 and 0xD6 port B, 0xD3 program counter, 0xD4 stack pointer, 0xD5 port A, 0xD7 upper half of port A, 0xD8 lower half of port A.
- R2: An operand byte in 0xA0–0xCF or 0xD9–0xFE gives status 0xB. No write occurs and the skip flag stays 0.
- R3: Opcodes 0xB0–0xB7 are add, subtract, multiply, divide, modulo, AND, OR and XOR. When operand 2 is 0x00 or 0xFF the result is accumulator op operand1; otherwise it is operand1 op operand2. The result is written to code 0xD0 with status 0x4, and it wraps modulo 2^16.
- R4: Division floors and modulo returns the remainder. A zero divisor gives status 0xD and no write.
- R5: 0xBA shifts left and 0xBB shifts right the register named by operand 1, by operand 2 bits. The result is written to that register code, and a shift of 16 or more gives 0. A literal in operand 1 gives status 0xB.
- R6: The compares are 0xC0 equal, 0xC1 less, 0xC2 less-or-equal, 0xC3 greater and 0xC4 greater-or-equal, each as unsigned operand1 versus operand2. A false result sets skip to 1. A compare never writes and ends with status 0x4.
- R7: Opcodes 0xE0–0xE8 use the literal {operand1, operand2}, with operand 1 as the high byte. 0xE0–0xE7 apply the R3 operation order to the accumulator and this literal, and 0xE8 loads the literal. A zero divisor on 0xE3/0xE4 gives status 0xD.
- R8: A missing operand (0xFF) gives status 0xC and no write. For 0xB0–0xB7 this applies to operand 1; for shifts and compares it applies to either operand.
- R9: Any opcode not listed gives status 0xA with no write and no skip.
- R10: Exactly one result follows each accepted instruction, one cycle later. `in_ready` is high when the output is empty or is being taken. A result waiting with `out_ready` low stays unchanged.
- R11: While reset is asserted the output is empty and `in_ready` is high. When no write occurs, the write code and write data read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when high with in_valid |
| in_opcode | input | 8 | Opcode byte |
| in_opa | input | 8 | Operand 1 byte |
| in_opb | input | 8 | Operand 2 byte |
| rf_acc | input | DATA_W | Accumulator value |
| rf_status | input | 4 | Status register value |
| rf_pc | input | 8 | Program counter value |
| rf_sp | input | 4 | Stack pointer value |
| rf_porta | input | DATA_W | Port A register value |
| rf_portb | input | 8 | Port B register value |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_wr_en | output | 1 | Result requests a register write |
| out_wr_code | output | 8 | Destination register code |
| out_wr_data | output | DATA_W | Data to write |
| out_skip | output | 1 | Next instruction is to be skipped |
| out_status | output | 4 | Status code of the instruction |

## Verification
The bench builds the block with its default width of 16 bits, so the wide-literal opcodes can reach the whole data range. At that width, wrap-around on add, subtract and multiply is observable at 0xFFFF and 0x10000. Shifts by exactly the width give zero, and the upper and lower halves of port A are whole bytes. This makes the half-register codes 0xD7 and 0xD8 checkable against byte values.

// File: rtl/bop_pkg.sv
package bop_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] LIT_MAX  = 8'h9F;
  localparam logic [7:0] ABSENT   = 8'hFF;

  localparam logic [7:0] CODE_ACC  = 8'hD0;
  localparam logic [7:0] CODE_STAT = 8'hD1;
  localparam logic [7:0] CODE_PBA  = 8'hD2;
  localparam logic [7:0] CODE_PC   = 8'hD3;
  localparam logic [7:0] CODE_SP   = 8'hD4;
  localparam logic [7:0] CODE_PA   = 8'hD5;
  localparam logic [7:0] CODE_PB   = 8'hD6;
  localparam logic [7:0] CODE_PAH  = 8'hD7;
  localparam logic [7:0] CODE_PAL  = 8'hD8;

  localparam logic [3:0] ST_DONE   = 4'h4;
  localparam logic [3:0] ST_BADOP  = 4'hA;
  localparam logic [3:0] ST_BADARG = 4'hB;
  localparam logic [3:0] ST_ARGCNT = 4'hC;
  localparam logic [3:0] ST_MATH   = 4'hD;

  typedef enum logic [2:0] {
    GRP_NONE, GRP_BIN, GRP_SHF, GRP_CMP, GRP_LIT
  } grp_e;
endpackage

// File: rtl/bop_operand.sv
module bop_operand
  import bop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [7:0]        code,
  input  logic [DATA_W-1:0] rf_acc,
  input  logic [3:0]        rf_status,
  input  logic [7:0]        rf_pc,
  input  logic [3:0]        rf_sp,
  input  logic [DATA_W-1:0] rf_porta,
  input  logic [7:0]        rf_portb,
  output logic              legal,
  output logic [DATA_W-1:0] value
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    legal = 1'b1;
    value = '0;
    if (code <= LIT_MAX) begin
      value = DATA_W'(code);
    end else begin
      case (code)
        CODE_ACC:          value = rf_acc;
        CODE_STAT:         value = DATA_W'(rf_status);
        CODE_PBA, CODE_PB: value = DATA_W'(rf_portb);
        CODE_PC:           value = DATA_W'(rf_pc);
        CODE_SP:           value = DATA_W'(rf_sp);
        CODE_PA:           value = rf_porta;
        CODE_PAH:          value = DATA_W'(rf_porta[DATA_W-1 -: HALF_W]);
        CODE_PAL:          value = DATA_W'(rf_porta[HALF_W-1:0]);
        default:           legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bop_core.sv
module bop_core
  import bop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [7:0]        opcode,
  input  logic [7:0]        opa,
  input  logic [7:0]        opb,
  input  logic [DATA_W-1:0] rf_acc,
  input  logic [3:0]        rf_status,
  input  logic [7:0]        rf_pc,
  input  logic [3:0]        rf_sp,
  input  logic [DATA_W-1:0] rf_porta,
  input  logic [7:0]        rf_portb,
  output logic              wr_en,
  output logic [7:0]        wr_code,
  output logic [DATA_W-1:0] wr_data,
  output logic              skip,
  output logic [3:0]        status
);
  localparam int NOPS = 2;

  logic [7:0]        codes  [NOPS];
  logic              legal  [NOPS];
  logic [DATA_W-1:0] vals   [NOPS];

  assign codes[0] = opa;
  assign codes[1] = opb;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    bop_operand #(.DATA_W(DATA_W)) u_opnd (
      .code(codes[g]), .rf_acc(rf_acc), .rf_status(rf_status), .rf_pc(rf_pc),
      .rf_sp(rf_sp), .rf_porta(rf_porta), .rf_portb(rf_portb),
      .legal(legal[g]), .value(vals[g])
    );
  end

  grp_e              grp;
  logic              one_form, divz, cond, a_miss, b_miss;
  logic [DATA_W-1:0] x, y, res;
  logic [3:0]        fn;

  assign fn     = opcode[3:0];
  assign a_miss = (opa == ABSENT);
  assign b_miss = (opb == ABSENT);

  always_comb begin
    if (opcode[7:3] == 5'b10110)                        grp = GRP_BIN;
    else if (opcode == 8'hBA || opcode == 8'hBB)        grp = GRP_SHF;
    else if (opcode >= 8'hC0 && opcode <= 8'hC4)        grp = GRP_CMP;
    else if (opcode >= 8'hE0 && opcode <= 8'hE8)        grp = GRP_LIT;
    else                                                grp = GRP_NONE;
  end

  // Operand routing for the arithmetic unit
  always_comb begin
    one_form = (opb == 8'h00) || b_miss;
    if (grp == GRP_LIT) begin
      x = rf_acc;
      y = DATA_W'({opa, opb});
    end else if (grp == GRP_BIN && one_form) begin
      x = rf_acc;
      y = vals[0];
    end else begin
      x = vals[0];
      y = vals[1];
    end
  end

  always_comb begin
    divz = 1'b0;
    res  = '0;
    if (grp == GRP_SHF) begin
      if (y >= DATA_W[DATA_W-1:0]) res = '0;
      else if (opcode[0])          res = x >> y;
      else                         res = x << y;
    end else begin
      case (fn)
        4'd0: res = x + y;
        4'd1: res = x - y;
        4'd2: res = x * y;
        4'd3: if (y == '0) divz = 1'b1; else res = x / y;
        4'd4: if (y == '0) divz = 1'b1; else res = x % y;
        4'd5: res = x & y;
        4'd6: res = x | y;
        4'd7: res = x ^ y;
        4'd8: res = y;
        default: res = '0;
      endcase
    end
  end

  always_comb begin
    case (opcode[2:0])
      3'd0:    cond = (x == y);
      3'd1:    cond = (x <  y);
      3'd2:    cond = (x <= y);
      3'd3:    cond = (x >  y);
      default: cond = (x >= y);
    endcase
  end

  // Status priority: opcode, operand count, operand legality, arithmetic
  always_comb begin
    wr_en   = 1'b0;
    wr_code = '0;
    wr_data = '0;
    skip    = 1'b0;
    status  = ST_DONE;
    case (grp)
      GRP_BIN: begin
        if (a_miss)                                 status = ST_ARGCNT;
        else if (!legal[0] || (!one_form && !legal[1])) status = ST_BADARG;
        else if (divz)                              status = ST_MATH;
        else begin wr_en = 1'b1; wr_code = CODE_ACC; wr_data = res; end
      end
      GRP_SHF: begin
        if (a_miss || b_miss)                       status = ST_ARGCNT;
        else if (!legal[0] || !legal[1] || opa <= LIT_MAX) status = ST_BADARG;
        else begin wr_en = 1'b1; wr_code = opa; wr_data = res; end
      end
      GRP_CMP: begin
        if (a_miss || b_miss)                       status = ST_ARGCNT;
        else if (!legal[0] || !legal[1])            status = ST_BADARG;
        else                                        skip = !cond;
      end
      GRP_LIT: begin
        if (divz)                                   status = ST_MATH;
        else begin wr_en = 1'b1; wr_code = CODE_ACC; wr_data = res; end
      end
      default:                                      status = ST_BADOP;
    endcase
  end
endmodule

// File: rtl/byte_op_alu.sv
module byte_op_alu
  import bop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [7:0]        in_opa,
  input  logic [7:0]        in_opb,
  input  logic [DATA_W-1:0] rf_acc,
  input  logic [3:0]        rf_status,
  input  logic [7:0]        rf_pc,
  input  logic [3:0]        rf_sp,
  input  logic [DATA_W-1:0] rf_porta,
  input  logic [7:0]        rf_portb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr_en,
  output logic [7:0]        out_wr_code,
  output logic [DATA_W-1:0] out_wr_data,
  output logic              out_skip,
  output logic [3:0]        out_status
);
  logic              c_wr_en, c_skip, accept;
  logic [7:0]        c_wr_code;
  logic [DATA_W-1:0] c_wr_data;
  logic [3:0]        c_status;

  bop_core #(.DATA_W(DATA_W)) u_core (
    .opcode(in_opcode), .opa(in_opa), .opb(in_opb),
    .rf_acc(rf_acc), .rf_status(rf_status), .rf_pc(rf_pc), .rf_sp(rf_sp),
    .rf_porta(rf_porta), .rf_portb(rf_portb),
    .wr_en(c_wr_en), .wr_code(c_wr_code), .wr_data(c_wr_data),
    .skip(c_skip), .status(c_status)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_wr_code <= '0;
      out_wr_data <= '0;
      out_skip    <= 1'b0;
      out_status  <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_wr_en   <= c_wr_en;
      out_wr_code <= c_wr_code;
      out_wr_data <= c_wr_data;
      out_skip    <= c_skip;
      out_status  <= c_status;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/bop_checker.sv
module bop_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_opcode,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_wr_en,
  input logic [7:0]        out_wr_code,
  input logic [DATA_W-1:0] out_wr_data,
  input logic              out_skip,
  input logic [3:0]        out_status
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_wr_data) && $stable(out_wr_en)
      && $stable(out_wr_code) && $stable(out_skip) && $stable(out_status));

  // R10
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R6
  skip_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_skip |-> out_status == 4'h4 && !out_wr_en);

  // R2
  error_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status != 4'h4 |-> !out_wr_en && !out_skip);

  // R9
  low_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode < 8'hB0 |=> out_status == 4'hA);

  // R3
  bin_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode[7:3] == 5'b10110 |=> !out_wr_en || out_wr_code == 8'hD0);

  // R11
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind byte_op_alu bop_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .out_valid(out_valid), .out_ready(out_ready),
  .out_wr_en(out_wr_en), .out_wr_code(out_wr_code), .out_wr_data(out_wr_data),
  .out_skip(out_skip), .out_status(out_status)
);

// File: tb/sim_byte_op_alu.sv
module sim_byte_op_alu;
  localparam int PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int NV = 55;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_opcode = '0, in_opa = '0, in_opb = '0;
  logic [DATA_W-1:0] rf_acc = '0;
  logic [3:0]        rf_status = 4'h3;
  logic [7:0]        rf_pc = 8'h2A;
  logic [3:0]        rf_sp = 4'h5;
  logic [DATA_W-1:0] rf_porta = 16'h1234;
  logic [7:0]        rf_portb = 8'h56;
  logic              out_valid, out_ready = 1'b1;
  logic              out_wr_en, out_skip;
  logic [7:0]        out_wr_code;
  logic [DATA_W-1:0] out_wr_data;
  logic [3:0]        out_status;

  int checks = 0;
  int failures = 0;

  always #(PERIOD/2) clk = ~clk;

  byte_op_alu #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_opa(in_opa), .in_opb(in_opb),
    .rf_acc(rf_acc), .rf_status(rf_status), .rf_pc(rf_pc), .rf_sp(rf_sp),
    .rf_porta(rf_porta), .rf_portb(rf_portb),
    .out_valid(out_valid), .out_ready(out_ready), .out_wr_en(out_wr_en),
    .out_wr_code(out_wr_code), .out_wr_data(out_wr_data),
    .out_skip(out_skip), .out_status(out_status)
  );

  // op, opa, opb, acc, req, wr_en, wr_code, wr_data, skip, status
  typedef logic [73:0] vec_t;
  localparam vec_t VECS [NV] = '{
    // R3 one- and two-operand forms, wrap
    {8'hB0,8'h05,8'h03,16'h0010,4'd3,1'b1,8'hD0,16'h0008,1'b0,4'h4},
    {8'hB0,8'h05,8'h00,16'h0010,4'd3,1'b1,8'hD0,16'h0015,1'b0,4'h4},
    {8'hB0,8'h05,8'hFF,16'h0010,4'd3,1'b1,8'hD0,16'h0015,1'b0,4'h4},
    {8'hB1,8'h03,8'h05,16'h0000,4'd3,1'b1,8'hD0,16'hFFFE,1'b0,4'h4},
    // R1 register reads
    {8'hB2,8'hD5,8'h02,16'h0000,4'd1,1'b1,8'hD0,16'h2468,1'b0,4'h4},
    {8'hB2,8'hD5,8'hD5,16'h0000,4'd3,1'b1,8'hD0,16'h5A90,1'b0,4'h4},
    // R4 division
    {8'hB3,8'h64,8'h07,16'h0000,4'd4,1'b1,8'hD0,16'h000E,1'b0,4'h4},
    {8'hB4,8'h64,8'h07,16'h0000,4'd4,1'b1,8'hD0,16'h0002,1'b0,4'h4},
    {8'hB3,8'h05,8'hD0,16'h0000,4'd4,1'b0,8'h00,16'h0000,1'b0,4'hD},
    {8'hB4,8'h00,8'h00,16'h0007,4'd4,1'b0,8'h00,16'h0000,1'b0,4'hD},
    {8'hB3,8'h9F,8'h00,16'h0100,4'd4,1'b1,8'hD0,16'h0001,1'b0,4'h4},
    {8'hB5,8'hD7,8'h0F,16'h0000,4'd1,1'b1,8'hD0,16'h0002,1'b0,4'h4},
    {8'hB6,8'hD8,8'h00,16'h0100,4'd1,1'b1,8'hD0,16'h0134,1'b0,4'h4},
    {8'hB7,8'hD6,8'hD1,16'h0000,4'd1,1'b1,8'hD0,16'h0055,1'b0,4'h4},
    {8'hB0,8'hD3,8'hD4,16'h0000,4'd1,1'b1,8'hD0,16'h002F,1'b0,4'h4},
    {8'hB0,8'hD2,8'h00,16'h0001,4'd1,1'b1,8'hD0,16'h0057,1'b0,4'h4},
    {8'hB1,8'hD0,8'h00,16'h0009,4'd3,1'b1,8'hD0,16'h0000,1'b0,4'h4},
    // R5 shifts
    {8'hBA,8'hD5,8'h04,16'h0000,4'd5,1'b1,8'hD5,16'h2340,1'b0,4'h4},
    {8'hBB,8'hD7,8'h01,16'h0000,4'd5,1'b1,8'hD7,16'h0009,1'b0,4'h4},
    {8'hBA,8'hD0,8'h10,16'hFFFF,4'd5,1'b1,8'hD0,16'h0000,1'b0,4'h4},
    {8'hBB,8'hD0,8'hD1,16'h0080,4'd5,1'b1,8'hD0,16'h0010,1'b0,4'h4},
    {8'hBA,8'h05,8'h01,16'h0000,4'd5,1'b0,8'h00,16'h0000,1'b0,4'hB},
    {8'hBA,8'hD0,8'hFF,16'h0000,4'd8,1'b0,8'h00,16'h0000,1'b0,4'hC},
    // R6 compares
    {8'hC0,8'h05,8'h05,16'h0000,4'd6,1'b0,8'h00,16'h0000,1'b0,4'h4},
    {8'hC0,8'h05,8'h06,16'h0000,4'd6,1'b0,8'h00,16'h0000,1'b1,4'h4},
    {8'hC1,8'h05,8'h06,16'h0000,4'd6,1'b0,8'h00,16'h0000,1'b0,4'h4},
    {8'hC1,8'h06,8'h05,16'h0000,4'd6,1'b0,8'h00,16'h0000,1'b1,4'h4},
    {8'hC2,8'h06,8'h06,16'h0000,4'd6,1'b0,8'h00,16'h0000,1'b0,4'h4},
    {8'hC3,8'hD0,8'h09,16'h0100,4'd6,1'b0,8'h00,16'h0000,1'b0,4'h4},
    {8'hC3,8'h09,8'hD0,16'h0100,4'd6,1'b0,8'h00,16'h0000,1'b1,4'h4},
    {8'hC4,8'h03,8'hD1,16'h0000,4'd6,1'b0,8'h00,16'h0000,1'b0,4'h4},
    {8'hC4,8'h02,8'hD1,16'h0000,4'd6,1'b0,8'h00,16'h0000,1'b1,4'h4},
    {8'hC1,8'hFF,8'h05,16'h0000,4'd8,1'b0,8'h00,16'h0000,1'b0,4'hC},
    // R7 wide literals
    {8'hE0,8'h12,8'h34,16'h0001,4'd7,1'b1,8'hD0,16'h1235,1'b0,4'h4},
    {8'hE1,8'h00,8'h02,16'h0001,4'd7,1'b1,8'hD0,16'hFFFF,1'b0,4'h4},
    {8'hE2,8'h01,8'h00,16'h0100,4'd7,1'b1,8'hD0,16'h0000,1'b0,4'h4},
    {8'hE3,8'h00,8'h07,16'h0064,4'd7,1'b1,8'hD0,16'h000E,1'b0,4'h4},
    {8'hE4,8'h00,8'h07,16'h0064,4'd7,1'b1,8'hD0,16'h0002,1'b0,4'h4},
    {8'hE3,8'h00,8'h00,16'h0064,4'd7,1'b0,8'h00,16'h0000,1'b0,4'hD},
    {8'hE5,8'h0F,8'hF0,16'hFFFF,4'd7,1'b1,8'hD0,16'h0FF0,1'b0,4'h4},
    {8'hE6,8'hF0,8'h00,16'h000F,4'd7,1'b1,8'hD0,16'hF00F,1'b0,4'h4},
    {8'hE7,8'hFF,8'hFF,16'h1234,4'd7,1'b1,8'hD0,16'hEDCB,1'b0,4'h4},
    {8'hE8,8'hAB,8'hCD,16'h0000,4'd7,1'b1,8'hD0,16'hABCD,1'b0,4'h4},
    // R2 illegal operand bytes
    {8'hB0,8'hA5,8'h01,16'h0000,4'd2,1'b0,8'h00,16'h0000,1'b0,4'hB},
    {8'hB0,8'h05,8'hD9,16'h0000,4'd2,1'b0,8'h00,16'h0000,1'b0,4'hB},
    {8'hB0,8'hFE,8'h00,16'h0000,4'd2,1'b0,8'h00,16'h0000,1'b0,4'hB},
    {8'hC0,8'hA0,8'h05,16'h0000,4'd2,1'b0,8'h00,16'h0000,1'b0,4'hB},
    // R8 missing operands
    {8'hB0,8'hFF,8'hFF,16'h0000,4'd8,1'b0,8'h00,16'h0000,1'b0,4'hC},
    {8'hB0,8'hFF,8'h05,16'h0000,4'd8,1'b0,8'h00,16'h0000,1'b0,4'hC},
    // R9 unlisted opcodes
    {8'h00,8'h00,8'h00,16'h0000,4'd9,1'b0,8'h00,16'h0000,1'b0,4'hA},
    {8'hA0,8'h05,8'hD0,16'h0000,4'd9,1'b0,8'h00,16'h0000,1'b0,4'hA},
    {8'hE9,8'h00,8'h00,16'h0000,4'd9,1'b0,8'h00,16'h0000,1'b0,4'hA},
    {8'hFF,8'hFF,8'hFF,16'h0000,4'd9,1'b0,8'h00,16'h0000,1'b0,4'hA},
    {8'hB8,8'h01,8'h02,16'h0000,4'd9,1'b0,8'h00,16'h0000,1'b0,4'hA},
    {8'hC5,8'h01,8'h01,16'h0000,4'd9,1'b0,8'h00,16'h0000,1'b0,4'hA}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] acc);
    in_opcode = op; in_opa = a; in_opb = b; rf_acc = acc; in_valid = 1'b1;
  endtask

  initial begin
    #(PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [29:0] want, got;
    // R11 reset state
    #(PERIOD * 2 + 1);
    check(out_valid == 1'b0, "R11", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R11", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v[73:66], v[65:58], v[57:50], v[49:34]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      want = {1'b1, v[29:0]};
      got  = {out_valid, out_wr_en, out_wr_code, out_wr_data, out_skip, out_status};
      checks++;
      if (got !== want) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", v[33:30], i, got, want);
      end
    end

    // R10 back-pressure: result held, input stalled, then both move together
    @(negedge clk);
    out_ready = 1'b0;
    drive(8'hE8, 8'h00, 8'h11, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R10", 32'(in_ready), 32'd0);
    drive(8'hE8, 8'h00, 8'h22, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    check(out_valid && out_wr_data == 16'h0011, "R10", 32'(out_wr_data), 32'h11);
    check(in_ready == 1'b0, "R10", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_wr_data == 16'h0022, "R10", 32'(out_wr_data), 32'h22);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);

    // R11 reset while a result waits
    out_ready = 1'b0;
    drive(8'hE8, 8'h00, 8'h33, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R11", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R11", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule